// File: doc/BRIEF.md
# Triggered DAC Sample FIFO Controller

This block sits between a processor or DMA engine and the input register of a digital-to-analog converter. Software or DMA pushes 12-bit samples into a small queue. The block presents one sample on its converter code output each time a conversion trigger arrives. The trigger comes either from a hardware pulse input or from a software strobe bit in the control word, and a control bit selects which one is used.

The block tracks a write pointer, a read pointer and an occupancy count. From these it reports several status signals: full, exactly-one-left, and read pointer at a programmed watermark. It also holds sticky underflow and overflow flags.

Control options:
- With the queue switched off, the block holds a single sample.
- In swing-back mode, the read pointer sweeps up and down over the stored entries without consuming them, so a short waveform repeats.
- An enabled status condition raises either an interrupt line or a DMA request line. A DMA-mode bit chooses which.

Top module: `dac_sample_fifo_ctrl`

## Requirements
- R1: A sample write stores the low 12 bits of `smp_wdata` and ignores the upper bits. Each accepted write advances the write pointer by one, modulo the depth. `wr_ptr` and `rd_ptr` show the pointers zero-extended to 8 bits.
- R2: The depth is 2^(DEPTH_CODE+1). `status[0]` (full) is 1 exactly when the stored count equals the current capacity.
- R3: A sample write while full sets the sticky overflow flag `status[4]`. The sample is dropped and the write pointer does not move, even if a trigger occurs in the same cycle.
- R4: Control bit 8 (run) gates all triggers, and control bit 7 selects the source. With bit 7 = 0, `hw_trig` high for a cycle is a trigger. With bit 7 = 1, a control write with bit 6 set is a trigger. The source that is not selected has no effect.
- R5: A trigger while a sample is stored puts the oldest sample on `dac_code`. `dac_update` pulses high for the one cycle after the trigger edge.
- R6: A trigger with nothing stored, outside swing-back mode, sets the sticky underflow flag `status[3]`. `dac_code` holds its value and `dac_update` stays low.
- R7: `status[1]` is 1 exactly when one sample is stored.
- R8: `status[2]` is 1 when the read pointer equals the watermark level in control bits 23:16.
- R9: A control write with bit 0 set clears underflow, and one with bit 1 set clears overflow. A write with either bit at 0 leaves that flag unchanged.
- R10: With control bit 9 = 0 the capacity is one sample. A second write before a trigger overflows, and the next trigger outputs the first sample.
- R11: Control bit 10 (with bit 9 = 1) selects swing-back mode. Triggers read entries upward to the last written entry, then downward to entry 0, and repeat without revisiting either end. The count is unchanged, and no underflow is raised.
- R12: A status condition raises a request when its enable is set: full with bit 2, one-left with bit 3, watermark with bit 4, and underflow or overflow with bit 5. One cycle later the request appears on `irq` if bit 11 = 0, or on `dma_req` if bit 11 = 1, never on both.
- R13: Each control write loads bits 2..5, 7..11 and 23:16 and reads them back on `ctrl_rdata`. Bit 12 clears the pointers, the count and both sticky flags, and keeps the control bits. Bit 13 returns every register, including `dac_code` and the control bits, to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_we | input | 1 | Sample write strobe |
| smp_wdata | input | WORD_W | Sample word, sample in low 12 bits |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 32 | Control word |
| hw_trig | input | 1 | Hardware conversion trigger |
| ctrl_rdata | output | 32 | Stored control bits |
| status | output | 5 | {overflow, underflow, watermark, one-left, full} |
| wr_ptr | output | PTR_W | Write pointer |
| rd_ptr | output | PTR_W | Read pointer |
| dac_code | output | SMP_W | Converter code |
| dac_update | output | 1 | One-cycle update strobe for the converter |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench builds the block with DEPTH_CODE = 1, which gives four entries. At that depth, pointer wraparound, the full flag and overflow are reached with only four or five writes. A watermark level of 2 lands inside the read-pointer range, and swing-back reversal at both ends shows up within six triggers. The default depth of sixteen is still elaborated by the lint pass.

// File: rtl/dacq_pkg.sv
`timescale 1ns/1ps
package dacq_pkg;
  localparam int CW_W       = 32;
  localparam int B_CLR_UDF  = 0;
  localparam int B_CLR_OVF  = 1;
  localparam int B_IE_FULL  = 2;
  localparam int B_IE_NEMP  = 3;
  localparam int B_IE_WM    = 4;
  localparam int B_IE_ERR   = 5;
  localparam int B_SW_TRIG  = 6;
  localparam int B_TRIG_SRC = 7;
  localparam int B_RUN      = 8;
  localparam int B_FIFO_ON  = 9;
  localparam int B_SWING    = 10;
  localparam int B_DMA      = 11;
  localparam int B_FIFO_CLR = 12;
  localparam int B_SOFT_RST = 13;
  localparam int B_WML_LO   = 16;
  localparam int WML_W      = 8;

  typedef struct packed {
    logic [WML_W-1:0] wml;
    logic             dma;
    logic             swing;
    logic             fifo_on;
    logic             run;
    logic             trig_src;
    logic             ie_err;
    logic             ie_wm;
    logic             ie_nemp;
    logic             ie_full;
  } cfg_t;

  // bit 0 full ... bit 4 overflow
  typedef struct packed {
    logic ovf;
    logic udf;
    logic wm;
    logic nemp;
    logic full;
  } stat_t;

  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;
endpackage

// File: rtl/dacq_cfg_regs.sv
`timescale 1ns/1ps
module dacq_cfg_regs
  import dacq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ctrl_we,
  input  logic [CW_W-1:0] ctrl_wdata,
  input  logic            hw_trig,
  output cfg_t            cfg,
  output logic            trig,
  output logic            clr_udf,
  output logic            clr_ovf,
  output logic            fifo_clr,
  output logic            soft_rst,
  output logic [CW_W-1:0] ctrl_rdata
);
  cfg_t cfg_q, cfg_d;
  logic sw_strobe;
  logic unused_rsvd;

  assign unused_rsvd = ^{ctrl_wdata[CW_W-1:B_WML_LO+WML_W],
                         ctrl_wdata[B_WML_LO-1:B_SOFT_RST+1]};

  always_comb begin
    cfg_d          = '0;
    cfg_d.ie_full  = ctrl_wdata[B_IE_FULL];
    cfg_d.ie_nemp  = ctrl_wdata[B_IE_NEMP];
    cfg_d.ie_wm    = ctrl_wdata[B_IE_WM];
    cfg_d.ie_err   = ctrl_wdata[B_IE_ERR];
    cfg_d.trig_src = ctrl_wdata[B_TRIG_SRC];
    cfg_d.run      = ctrl_wdata[B_RUN];
    cfg_d.fifo_on  = ctrl_wdata[B_FIFO_ON];
    cfg_d.swing    = ctrl_wdata[B_SWING];
    cfg_d.dma      = ctrl_wdata[B_DMA];
    cfg_d.wml      = ctrl_wdata[B_WML_LO +: WML_W];
  end

  assign soft_rst  = ctrl_we & ctrl_wdata[B_SOFT_RST];
  assign fifo_clr  = ctrl_we & ctrl_wdata[B_FIFO_CLR];
  assign clr_udf   = ctrl_we & ctrl_wdata[B_CLR_UDF];
  assign clr_ovf   = ctrl_we & ctrl_wdata[B_CLR_OVF];
  assign sw_strobe = ctrl_we & ctrl_wdata[B_SW_TRIG];

  always_ff @(posedge clk) begin
    if (rst || soft_rst) cfg_q <= '0;
    else if (ctrl_we)    cfg_q <= cfg_d;
  end

  // trigger source picked by the stored select bit, gated by run
  assign trig = cfg_q.run & (cfg_q.trig_src ? sw_strobe : hw_trig);
  assign cfg  = cfg_q;

  always_comb begin
    ctrl_rdata                      = '0;
    ctrl_rdata[B_IE_FULL]           = cfg_q.ie_full;
    ctrl_rdata[B_IE_NEMP]           = cfg_q.ie_nemp;
    ctrl_rdata[B_IE_WM]             = cfg_q.ie_wm;
    ctrl_rdata[B_IE_ERR]            = cfg_q.ie_err;
    ctrl_rdata[B_TRIG_SRC]          = cfg_q.trig_src;
    ctrl_rdata[B_RUN]               = cfg_q.run;
    ctrl_rdata[B_FIFO_ON]           = cfg_q.fifo_on;
    ctrl_rdata[B_SWING]             = cfg_q.swing;
    ctrl_rdata[B_DMA]               = cfg_q.dma;
    ctrl_rdata[B_WML_LO +: WML_W]   = cfg_q.wml;
  end
endmodule

// File: rtl/dacq_store.sv
`timescale 1ns/1ps
module dacq_store
  import dacq_pkg::*;
#(
  parameter int SMP_W      = 12,
  parameter int DEPTH_CODE = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fifo_clr,
  input  logic                  soft_rst,
  input  logic                  smp_we,
  input  logic [SMP_W-1:0]      smp_data,
  input  logic                  trig,
  input  logic                  fifo_on,
  input  logic                  swing,
  output logic [DEPTH_CODE:0]   wptr,
  output logic [DEPTH_CODE:0]   rptr,
  output logic [DEPTH_CODE+1:0] cnt,
  output logic                  full,
  output logic                  ovf_evt,
  output logic                  udf_evt,
  output logic [SMP_W-1:0]      code,
  output logic                  update
);
  localparam int AW    = DEPTH_CODE + 1;
  localparam int DEPTH = 2 << DEPTH_CODE;
  localparam logic [AW:0]   DEPTH_C = (AW+1)'(DEPTH);
  localparam logic [AW:0]   CNT_ONE = (AW+1)'(1);
  localparam logic [AW-1:0] P_ONE   = AW'(1);
  localparam logic [AW-1:0] P_ZERO  = '0;

  logic [SMP_W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q, rptr_d, last;
  logic [AW:0]   cnt_q, cnt_d, cap;
  dir_e          dir_q, dir_d;
  logic          clr_any, have, wr_ok, rd_ok, pop;
  logic [SMP_W-1:0] code_q;
  logic          upd_q;

  assign clr_any = fifo_clr | soft_rst;
  assign cap     = fifo_on ? DEPTH_C : CNT_ONE;
  assign full    = (cnt_q >= cap);
  assign have    = (cnt_q != '0);
  assign wr_ok   = smp_we & ~full & ~clr_any;
  assign rd_ok   = trig & have & ~clr_any;
  assign pop     = rd_ok & ~swing;
  assign ovf_evt = smp_we & full & ~clr_any;
  assign udf_evt = trig & ~have & ~swing & ~clr_any;
  assign last    = wptr_q - P_ONE;

  // storage: single write port, registered read into the code register
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q] <= smp_data;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) code_q <= '0;
    else if (rd_ok)      code_q <= mem[rptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) upd_q <= 1'b0;
    else     upd_q <= rd_ok;
  end

  // read pointer walk: plain advance, or a bounce between entry 0 and the last write
  always_comb begin
    rptr_d = rptr_q;
    dir_d  = dir_q;
    if (pop) begin
      rptr_d = rptr_q + P_ONE;
    end else if (rd_ok && swing) begin
      if (dir_q == DIR_UP) begin
        if (rptr_q == last) begin
          dir_d  = DIR_DOWN;
          rptr_d = (rptr_q == P_ZERO) ? P_ZERO : rptr_q - P_ONE;
        end else begin
          rptr_d = rptr_q + P_ONE;
        end
      end else begin
        if (rptr_q == P_ZERO) begin
          dir_d  = DIR_UP;
          rptr_d = (last == P_ZERO) ? P_ZERO : P_ONE;
        end else begin
          rptr_d = rptr_q - P_ONE;
        end
      end
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (wr_ok && !pop)      cnt_d = cnt_q + CNT_ONE;
    else if (pop && !wr_ok) cnt_d = cnt_q - CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_any) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      dir_q  <= DIR_UP;
    end else begin
      if (wr_ok) wptr_q <= wptr_q + P_ONE;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
    end
  end

  assign wptr   = wptr_q;
  assign rptr   = rptr_q;
  assign cnt    = cnt_q;
  assign code   = code_q;
  assign update = upd_q;
endmodule

// File: rtl/dacq_events.sv
`timescale 1ns/1ps
module dacq_events
  import dacq_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  cfg_t        cfg,
  input  logic        full,
  input  logic [AW:0] cnt,
  input  logic [AW-1:0] rptr,
  input  logic        ovf_evt,
  input  logic        udf_evt,
  input  logic        clr_udf,
  input  logic        clr_ovf,
  input  logic        fifo_clr,
  input  logic        soft_rst,
  output stat_t       stat,
  output logic        irq,
  output logic        dma_req
);
  localparam logic [AW:0] CNT_ONE = (AW+1)'(1);

  logic udf_q, ovf_q, nemp, wm, src, irq_q, dma_q;

  assign nemp = (cnt == CNT_ONE);
  assign wm   = (WML_W'(rptr) == cfg.wml);

  always_ff @(posedge clk) begin
    if (rst || fifo_clr || soft_rst) begin
      udf_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      udf_q <= udf_evt | (udf_q & ~clr_udf);
      ovf_q <= ovf_evt | (ovf_q & ~clr_ovf);
    end
  end

  assign src = (full & cfg.ie_full) | (nemp & cfg.ie_nemp) |
               (wm & cfg.ie_wm) | ((udf_q | ovf_q) & cfg.ie_err);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      irq_q <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      irq_q <= src & ~cfg.dma;
      dma_q <= src & cfg.dma;
    end
  end

  always_comb begin
    stat.full = full;
    stat.nemp = nemp;
    stat.wm   = wm;
    stat.udf  = udf_q;
    stat.ovf  = ovf_q;
  end

  assign irq     = irq_q;
  assign dma_req = dma_q;
endmodule

// File: rtl/dac_sample_fifo_ctrl.sv
`timescale 1ns/1ps
module dac_sample_fifo_ctrl
  import dacq_pkg::*;
#(
  parameter int SMP_W      = 12,
  parameter int WORD_W     = 16,
  parameter int DEPTH_CODE = 3,
  parameter int PTR_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_we,
  input  logic [WORD_W-1:0] smp_wdata,
  input  logic              ctrl_we,
  input  logic [CW_W-1:0]   ctrl_wdata,
  input  logic              hw_trig,
  output logic [CW_W-1:0]   ctrl_rdata,
  output logic [4:0]        status,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [SMP_W-1:0]  dac_code,
  output logic              dac_update,
  output logic              irq,
  output logic              dma_req
);
  localparam int AW = DEPTH_CODE + 1;

  cfg_t          cfg;
  stat_t         stat;
  logic          trig, clr_udf, clr_ovf, fifo_clr, soft_rst, swing_eff;
  logic          full, ovf_evt, udf_evt;
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic          unused_hi;

  assign unused_hi = ^smp_wdata[WORD_W-1:SMP_W];
  assign swing_eff = cfg.swing & cfg.fifo_on;

  dacq_cfg_regs u_cfg (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .hw_trig    (hw_trig),
    .cfg        (cfg),
    .trig       (trig),
    .clr_udf    (clr_udf),
    .clr_ovf    (clr_ovf),
    .fifo_clr   (fifo_clr),
    .soft_rst   (soft_rst),
    .ctrl_rdata (ctrl_rdata)
  );

  dacq_store #(.SMP_W(SMP_W), .DEPTH_CODE(DEPTH_CODE)) u_store (
    .clk      (clk),
    .rst      (rst),
    .fifo_clr (fifo_clr),
    .soft_rst (soft_rst),
    .smp_we   (smp_we),
    .smp_data (smp_wdata[SMP_W-1:0]),
    .trig     (trig),
    .fifo_on  (cfg.fifo_on),
    .swing    (swing_eff),
    .wptr     (wptr),
    .rptr     (rptr),
    .cnt      (cnt),
    .full     (full),
    .ovf_evt  (ovf_evt),
    .udf_evt  (udf_evt),
    .code     (dac_code),
    .update   (dac_update)
  );

  dacq_events #(.AW(AW)) u_evt (
    .clk      (clk),
    .rst      (rst),
    .cfg      (cfg),
    .full     (full),
    .cnt      (cnt),
    .rptr     (rptr),
    .ovf_evt  (ovf_evt),
    .udf_evt  (udf_evt),
    .clr_udf  (clr_udf),
    .clr_ovf  (clr_ovf),
    .fifo_clr (fifo_clr),
    .soft_rst (soft_rst),
    .stat     (stat),
    .irq      (irq),
    .dma_req  (dma_req)
  );

  assign status = stat;
  assign wr_ptr = PTR_W'(wptr);
  assign rd_ptr = PTR_W'(rptr);
endmodule

// File: rtl/dacq_checker.sv
`timescale 1ns/1ps
module dacq_checker #(
  parameter int DEPTH_CODE = 3,
  parameter int SMP_W      = 12,
  parameter int PTR_W      = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  smp_we,
  input logic [4:0]            status,
  input logic [PTR_W-1:0]      wr_ptr,
  input logic [SMP_W-1:0]      dac_code,
  input logic                  dac_update,
  input logic                  irq,
  input logic                  dma_req,
  input logic                  soft_rst,
  input logic                  fifo_clr,
  input logic                  clr_ovf,
  input logic                  clr_udf,
  input logic                  swing_on,
  input logic [DEPTH_CODE+1:0] cnt
);
  localparam int DEPTH = 2 << DEPTH_CODE;

  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= (DEPTH_CODE+2)'(DEPTH));

  p_drop_when_full_r3: assert property (@(posedge clk) disable iff (rst)
    (smp_we && status[0] && !fifo_clr && !soft_rst) |=> $stable(wr_ptr));

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (status[4] && !clr_ovf && !fifo_clr && !soft_rst) |=> status[4]);

  p_udf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (status[3] && !clr_udf && !fifo_clr && !soft_rst) |=> status[3]);

  p_code_moves_on_update_r5: assert property (@(posedge clk) disable iff (rst)
    (dac_code != $past(dac_code)) |-> (dac_update || $past(soft_rst)));

  p_swing_no_udf_r11: assert property (@(posedge clk) disable iff (rst)
    (swing_on && !status[3]) |=> !status[3]);

  p_irq_dma_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(irq && dma_req));
endmodule

bind dac_sample_fifo_ctrl dacq_checker #(
  .DEPTH_CODE (DEPTH_CODE),
  .SMP_W      (SMP_W),
  .PTR_W      (PTR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .smp_we     (smp_we),
  .status     (status),
  .wr_ptr     (wr_ptr),
  .dac_code   (dac_code),
  .dac_update (dac_update),
  .irq        (irq),
  .dma_req    (dma_req),
  .soft_rst   (soft_rst),
  .fifo_clr   (fifo_clr),
  .clr_ovf    (clr_ovf),
  .clr_udf    (clr_udf),
  .swing_on   (swing_eff),
  .cnt        (cnt)
);

// File: tb/tb_dac_sample_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_dac_sample_fifo_ctrl;
  localparam int SMP_W = 12;
  localparam int WORD_W = 16;
  localparam int PTR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              smp_we = 1'b0;
  logic [WORD_W-1:0] smp_wdata = '0;
  logic              ctrl_we = 1'b0;
  logic [31:0]       ctrl_wdata = '0;
  logic              hw_trig = 1'b0;
  logic [31:0]       ctrl_rdata;
  logic [4:0]        status;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [SMP_W-1:0]  dac_code;
  logic              dac_update, irq, dma_req;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dac_sample_fifo_ctrl #(.SMP_W(SMP_W), .WORD_W(WORD_W), .DEPTH_CODE(1), .PTR_W(PTR_W)) dut (
    .clk(clk), .rst(rst), .smp_we(smp_we), .smp_wdata(smp_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .hw_trig(hw_trig),
    .ctrl_rdata(ctrl_rdata), .status(status), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .dac_code(dac_code), .dac_update(dac_update), .irq(irq), .dma_req(dma_req)
  );

  // {op(0 write,1 hw trigger), data, expected code, expected update, expected underflow}
  localparam logic [27:0] VEC [9] = '{
    {2'd0, 12'h111, 12'h000, 1'b0, 1'b0},
    {2'd0, 12'h222, 12'h000, 1'b0, 1'b0},
    {2'd0, 12'h333, 12'h000, 1'b0, 1'b0},
    {2'd1, 12'h000, 12'h111, 1'b1, 1'b0},
    {2'd1, 12'h000, 12'h222, 1'b1, 1'b0},
    {2'd1, 12'h000, 12'h333, 1'b1, 1'b0},
    {2'd1, 12'h000, 12'h333, 1'b0, 1'b1},
    {2'd0, 12'h5A5, 12'h333, 1'b0, 1'b1},
    {2'd1, 12'h000, 12'h5A5, 1'b1, 1'b1}
  };

  localparam logic [11:0] SWING_CODE [6] = '{12'h00A, 12'h00B, 12'h00C, 12'h00B, 12'h00A, 12'h00B};
  localparam logic [7:0]  SWING_PTR  [6] = '{8'd1, 8'd2, 8'd1, 8'd0, 8'd1, 8'd2};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_smp(input logic [11:0] d);
    @(negedge clk); smp_we = 1'b1; smp_wdata = {4'hF, d};
    @(negedge clk); smp_we = 1'b0; smp_wdata = '0;
  endtask

  task automatic ctrl(input logic [31:0] w);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = w;
    @(negedge clk); ctrl_we = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic hwt();
    @(negedge clk); hw_trig = 1'b1;
    @(negedge clk); hw_trig = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R13): level 0 equals read pointer 0, so watermark reads 1
    chk("R13 reset status", 32'(status), 32'h04);
    chk("R13 reset ctrl", ctrl_rdata, 32'h0);
    chk("R1 reset wr_ptr", 32'(wr_ptr), 32'h0);
    chk("R1 reset rd_ptr", 32'(rd_ptr), 32'h0);
    chk("R5 reset code", 32'(dac_code), 32'h0);
    chk("R12 reset irq", 32'(irq), 32'h0);
    chk("R12 reset dma", 32'(dma_req), 32'h0);

    // table walk: run + queue on, hardware source
    ctrl(32'h300);
    for (int i = 0; i < 9; i++) begin
      if (VEC[i][27:26] == 2'd0) wr_smp(VEC[i][25:14]);
      else hwt();
      chk("R1/R5 table code", 32'(dac_code), 32'(VEC[i][13:2]));
      chk("R5 table update", 32'(dac_update), 32'(VEC[i][1]));
      chk("R6 table underflow", 32'(status[3]), 32'(VEC[i][0]));
    end
    ctrl(32'h301);
    chk("R9 underflow cleared", 32'(status[3]), 32'h0);

    // fill to full, then overflow
    for (int i = 0; i < 4; i++) wr_smp(12'h010 + 12'(i));
    chk("R2 full", 32'(status[0]), 32'h1);
    chk("R1 wr_ptr wraps", 32'(wr_ptr), 32'h0);
    chk("R7 not one-left at four", 32'(status[1]), 32'h0);
    wr_smp(12'h099);
    chk("R3 overflow set", 32'(status[4]), 32'h1);
    chk("R3 wr_ptr unchanged", 32'(wr_ptr), 32'h0);
    for (int i = 0; i < 3; i++) begin
      hwt();
      chk("R5 drain code", 32'(dac_code), 32'h10 + 32'(i));
    end
    chk("R7 one left", 32'(status[1]), 32'h1);
    chk("R2 not full after drain", 32'(status[0]), 32'h0);
    hwt();
    chk("R3 last code is pre-overflow sample", 32'(dac_code), 32'h13);
    chk("R7 none left", 32'(status[1]), 32'h0);
    hwt();
    chk("R3 dropped sample absent", 32'(dac_code), 32'h13);
    chk("R6 underflow after drain", 32'(status[3]), 32'h1);
    ctrl(32'h300);
    chk("R9 zero bit keeps underflow", 32'(status[3]), 32'h1);
    chk("R9 zero bit keeps overflow", 32'(status[4]), 32'h1);
    ctrl(32'h302);
    chk("R9 overflow cleared", 32'(status[4]), 32'h0);
    chk("R9 underflow untouched", 32'(status[3]), 32'h1);
    ctrl(32'h301);

    // software source
    ctrl(32'h380);
    wr_smp(12'h777);
    hwt();
    chk("R4 hw ignored update", 32'(dac_update), 32'h0);
    chk("R4 hw ignored code", 32'(dac_code), 32'h13);
    ctrl(32'h3C0);
    chk("R4 sw trigger update", 32'(dac_update), 32'h1);
    chk("R4 sw trigger code", 32'(dac_code), 32'h777);

    // run off gates triggers
    ctrl(32'h200);
    wr_smp(12'h444);
    hwt();
    chk("R4 run off no update", 32'(dac_update), 32'h0);
    chk("R4 run off rd_ptr", 32'(rd_ptr), 32'h1);
    chk("R4 run off sample kept", 32'(status[1]), 32'h1);
    ctrl(32'h300);
    hwt();
    chk("R4 run on code", 32'(dac_code), 32'h444);

    // single-entry mode
    ctrl(32'h100);
    wr_smp(12'hA01);
    chk("R10 full at one", 32'(status[0]), 32'h1);
    wr_smp(12'hA02);
    chk("R10 second write overflows", 32'(status[4]), 32'h1);
    hwt();
    chk("R10 first sample out", 32'(dac_code), 32'hA01);
    ctrl(32'h102);

    // queue clear
    ctrl(32'h300);
    wr_smp(12'h051);
    wr_smp(12'h052);
    ctrl(32'h1300);
    chk("R13 clear wr_ptr", 32'(wr_ptr), 32'h0);
    chk("R13 clear rd_ptr", 32'(rd_ptr), 32'h0);
    chk("R13 clear status", 32'(status & 5'b11011), 32'h0);
    chk("R13 clear keeps ctrl", ctrl_rdata, 32'h300);
    hwt();
    chk("R13 empty after clear", 32'(status[3]), 32'h1);
    ctrl(32'h301);

    // swing-back
    wr_smp(12'h00A);
    wr_smp(12'h00B);
    wr_smp(12'h00C);
    ctrl(32'h700);
    for (int i = 0; i < 6; i++) begin
      hwt();
      chk("R11 swing code", 32'(dac_code), 32'(SWING_CODE[i]));
      chk("R11 swing rd_ptr", 32'(rd_ptr), 32'(SWING_PTR[i]));
    end
    chk("R11 no underflow", 32'(status[3]), 32'h0);
    chk("R11 nothing consumed", 32'(status[1:0]), 32'h0);

    // watermark, interrupt and DMA routing
    ctrl(32'h1300);
    ctrl(32'h20310);
    chk("R8 below level", 32'(status[2]), 32'h0);
    for (int i = 0; i < 4; i++) wr_smp(12'h020 + 12'(i));
    hwt();
    hwt();
    chk("R8 level reached", 32'(status[2]), 32'h1);
    @(negedge clk);
    chk("R12 irq raised", 32'(irq), 32'h1);
    chk("R12 dma idle", 32'(dma_req), 32'h0);
    ctrl(32'h20B10);
    @(negedge clk);
    chk("R12 irq off in dma mode", 32'(irq), 32'h0);
    chk("R12 dma raised", 32'(dma_req), 32'h1);
    hwt();
    chk("R8 past level", 32'(status[2]), 32'h0);
    @(negedge clk);
    chk("R12 dma dropped", 32'(dma_req), 32'h0);

    // soft reset
    ctrl(32'h2000);
    chk("R13 soft ctrl", ctrl_rdata, 32'h0);
    chk("R13 soft code", 32'(dac_code), 32'h0);
    chk("R13 soft wr_ptr", 32'(wr_ptr), 32'h0);
    chk("R13 soft rd_ptr", 32'(rd_ptr), 32'h0);
    chk("R13 soft status", 32'(status), 32'h04);
    chk("R13 soft dma", 32'(dma_req), 32'h0);

    finish_run();
  end
endmodule